// File: doc/BRIEF.md
# SPI Host Byte Shifter

This block is the host side of an SPI link that exchanges one byte per transfer. Software places a byte in the data register, and that write starts the exchange at once. There is no separate start command. The block then generates the serial clock and sends the byte out most significant bit first. At the same time it collects a byte from the serial input. When the eighth bit has been taken in, the collected byte is copied into a readable buffer, and two flags rise: a buffer-full status flag and an interrupt flag.

The half-bit time comes from one of five sources. Three are fixed prescalers of the system clock. One is an external timer pulse, where each pulse is one half-bit. The last is a divider driven by an 8-bit reload value. Three further control bits set the serial behaviour:
- the clock idle level;
- whether output data leads the first clock edge of each bit;
- whether input is captured at mid-bit or at the end of the bit.

A mute bit releases the data output for receive-only use. Shifting continues while the output is muted.

Top module: `spi_byte_host`

## Requirements
- R1: A write to address 0 (data) while no transfer is running starts a transfer. Busy (status bit 2) reads 1 from the next clock edge, with no other command needed.
- R2: Each transfer moves 8 bits on `sdo`, most significant bit first.
- R3: The transfer ends after the last half-bit. At that point the received byte becomes readable at address 0, status bit 0 (buffer full) and bit 1 (interrupt) read 1, and the `irq` pin goes high.
- R4: A transfer takes 16 half-bits. The half-bit length in system clocks depends on the rate select in control bits [2:0]:
  - 0 gives 2 clocks;
  - 1 gives 8 clocks;
  - 2 gives 32 clocks;
  - 4 gives 2×(N+1) clocks, where N is the reload register at address 3.
  So the time from the start write to `irq` is 16 × half-bit clocks.
- R5: With rate select 3, every pulse on `tmr_tick` advances one half-bit. A byte completes on the 16th pulse and not before, and the pulse path adds one register stage.
- R6: While no transfer is running, `sck` sits at the idle level given by control bit 3.
- R7: Control bit 4 sets when `sck` first moves:
  - when it is 1, `sck` stays idle for the first half of each bit, so data is valid before the first edge;
  - when it is 0, `sck` leaves idle at the start of the bit.
- R8: Control bit 5 selects when `sdi` is captured: 0 captures at mid-bit, 1 captures at the end of the bit. In both settings a byte looped back from `sdo` is received unchanged.
- R9: Control bit 6 drives `sdo_oe` low, and input shifting still completes a byte from `sdi`.
- R10: A write to address 0 during a transfer sets status bit 3 (collision). The written byte is dropped and the running transfer is not disturbed.
- R11: Reading address 0 clears buffer full. Writing 1 to status bit 1 clears the interrupt, and writing 1 to status bit 3 clears the collision flag. Writing 0 to these bits leaves them unchanged.
- R12: After reset, status and control read 0, `sck` is low, `irq` is low and `sdo_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 0 clears buffer full) |
| addr | input | 2 | Register address: 0 data, 1 control, 2 status, 3 reload |
| wdata | input | BUS_W | Register write data |
| rdata | output | BUS_W | Register read data, combinational from `addr` |
| tmr_tick | input | 1 | External timer pulse for rate select 3 |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| irq | output | 1 | Transfer-complete interrupt flag |

## Verification
The start write registers at one clock edge, so busy and the first `sck` level are checked at the falling edge half a cycle later. Completion is due exactly 16 × half-bit clocks after that falling edge, and the bench counts falling edges until `irq` rises and compares the count. In timer mode, completion lags the 16th pulse by two edges because of the pulse register. The bench therefore checks `irq` low after 15 pulses and high three cycles after the 16th. Register reads are combinational and are sampled on the falling edge of the cycle that presents the address. A serial monitor checks bit order by capturing `sdo` on each leading `sck` edge and compares the result against a queue of expected bytes filled by the driver.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;

   typedef enum logic [1:0] {
      REG_DATA   = 2'd0,
      REG_CTRL   = 2'd1,
      REG_STAT   = 2'd2,
      REG_RELOAD = 2'd3
   } reg_addr_e;

   typedef enum logic [2:0] {
      RATE_DIV4   = 3'd0,
      RATE_DIV16  = 3'd1,
      RATE_DIV64  = 3'd2,
      RATE_TIMER  = 3'd3,
      RATE_RELOAD = 3'd4
   } rate_e;

   // control register layout, bit 6 down to bit 0
   typedef struct packed {
      logic       tx_mute;
      logic       late_sample;
      logic       lead_data;
      logic       idle_hi;
      logic [2:0] rate_sel;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
   localparam int STAT_W = 4;

endpackage

// File: rtl/spi_rate_gen.sv
`timescale 1ns/1ps
module spi_rate_gen
   import spi_host_pkg::*;
#(
   parameter int PRE_LO   = 4,
   parameter int PRE_MID  = 16,
   parameter int PRE_HI   = 64,
   parameter int RELOAD_W = 8,
   parameter bit TMR_SYNC = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [2:0]          rate_sel,
   input  logic [RELOAD_W-1:0] reload,
   input  logic                tmr_tick,
   output logic                half_tick
);

   localparam int HALF_LO      = PRE_LO / 2;
   localparam int HALF_MID     = PRE_MID / 2;
   localparam int HALF_HI      = PRE_HI / 2;
   localparam int HALF_RLD_MAX = 2 << RELOAD_W;
   localparam int HALF_MAX     = (HALF_RLD_MAX > HALF_HI) ? HALF_RLD_MAX : HALF_HI;
   localparam int CNT_W        = $clog2(HALF_MAX + 1);

   if (PRE_LO < 2 || (PRE_LO % 2) != 0) begin : g_bad_lo
      $error("spi_rate_gen: PRE_LO must be even and at least 2");
   end
   if (PRE_MID < PRE_LO || (PRE_MID % 2) != 0) begin : g_bad_mid
      $error("spi_rate_gen: PRE_MID must be even and not below PRE_LO");
   end
   if (PRE_HI < PRE_MID || (PRE_HI % 2) != 0) begin : g_bad_hi
      $error("spi_rate_gen: PRE_HI must be even and not below PRE_MID");
   end
   if (RELOAD_W < 1 || RELOAD_W > 16) begin : g_bad_rld
      $error("spi_rate_gen: RELOAD_W out of range");
   end

   logic [CNT_W-1:0] half_len;
   logic [CNT_W-1:0] cnt_q;
   logic             div_hit;
   logic             tmr_q;

   always_comb begin
      unique case (rate_e'(rate_sel))
         RATE_DIV4:  half_len = CNT_W'(HALF_LO);
         RATE_DIV16: half_len = CNT_W'(HALF_MID);
         RATE_DIV64: half_len = CNT_W'(HALF_HI);
         default:    half_len = (CNT_W'(reload) + CNT_W'(1)) << 1;
      endcase
   end

   // pulse path: registered or direct, chosen at elaboration
   if (TMR_SYNC) begin : g_tmr_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tmr_q <= 1'b0;
         else        tmr_q <= tmr_tick;
      end
   end else begin : g_tmr_raw
      assign tmr_q = tmr_tick;
   end

   assign div_hit = (cnt_q == half_len - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (div_hit) cnt_q <= '0;
      else              cnt_q <= cnt_q + CNT_W'(1);
   end

   assign half_tick = run & ((rate_e'(rate_sel) == RATE_TIMER) ? tmr_q : div_hit);

endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              half_tick,
   input  logic              idle_hi,
   input  logic              lead_data,
   input  logic              late_sample,
   input  logic              sdi,
   output logic              sck,
   output logic              sdo,
   output logic              active,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte
);

   localparam int PH_N = 2 * DATA_W;
   localparam int PH_W = $clog2(PH_N);

   if (DATA_W < 2) begin : g_bad_w
      $error("spi_shift_core: DATA_W must be at least 2");
   end

   logic [PH_W-1:0]   ph_q;
   logic              act_q;
   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic              last_ph;
   logic              capture;
   logic              bit_end;
   logic [DATA_W-1:0] rx_next;

   assign last_ph = (ph_q == PH_W'(PH_N - 1));
   // even phase = first half of a bit, odd phase = second half
   assign capture = act_q & half_tick & (ph_q[0] == late_sample);
   assign bit_end = act_q & half_tick & ph_q[0];
   assign rx_next = capture ? {rx_sr[DATA_W-2:0], sdi} : rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         ph_q  <= '0;
         tx_sr <= '0;
         rx_sr <= '0;
      end else if (start) begin
         act_q <= 1'b1;
         ph_q  <= '0;
         tx_sr <= tx_byte;
         rx_sr <= '0;
      end else begin
         if (act_q && half_tick) begin
            ph_q <= ph_q + PH_W'(1);
            if (last_ph) act_q <= 1'b0;
         end
         if (capture) rx_sr <= rx_next;
         if (bit_end && !last_ph) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
   end

   assign done    = act_q & half_tick & last_ph;
   assign rx_byte = rx_next;
   assign active  = act_q;
   assign sdo     = tx_sr[DATA_W-1];
   assign sck     = act_q ? (idle_hi ^ (lead_data ? ph_q[0] : ~ph_q[0])) : idle_hi;

endmodule

// File: rtl/spi_reg_file.sv
`timescale 1ns/1ps
module spi_reg_file
   import spi_host_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BUS_W    = 8,
   parameter int RELOAD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [1:0]          addr,
   input  logic [BUS_W-1:0]    wdata,
   output logic [BUS_W-1:0]    rdata,
   input  logic                active,
   input  logic                done,
   input  logic [DATA_W-1:0]   rx_byte,
   output logic                start,
   output logic [DATA_W-1:0]   tx_byte,
   output ctrl_t               ctrl,
   output logic [RELOAD_W-1:0] reload,
   output logic                full,
   output logic                irq_flag,
   output logic                wcol
);

   if (BUS_W < DATA_W || BUS_W < RELOAD_W || BUS_W < CTRL_W) begin : g_bad_bus
      $error("spi_reg_file: BUS_W narrower than a register");
   end

   logic              wr_data, wr_ctrl, wr_stat, wr_rld, rd_data;
   ctrl_t             ctrl_q;
   logic [RELOAD_W-1:0] rld_q;
   logic [DATA_W-1:0] rx_buf;

   assign wr_data = wr_en && (addr == REG_DATA);
   assign wr_ctrl = wr_en && (addr == REG_CTRL);
   assign wr_stat = wr_en && (addr == REG_STAT);
   assign wr_rld  = wr_en && (addr == REG_RELOAD);
   assign rd_data = rd_en && (addr == REG_DATA);

   assign start   = wr_data && !active;
   assign tx_byte = wdata[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         rld_q    <= '0;
         rx_buf   <= '0;
         full     <= 1'b0;
         irq_flag <= 1'b0;
         wcol     <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (wr_rld)  rld_q  <= wdata[RELOAD_W-1:0];
         if (done)    rx_buf <= rx_byte;

         if (done)         full <= 1'b1;
         else if (rd_data) full <= 1'b0;

         if (done)                     irq_flag <= 1'b1;
         else if (wr_stat && wdata[1]) irq_flag <= 1'b0;

         if (wr_data && active)        wcol <= 1'b1;
         else if (wr_stat && wdata[3]) wcol <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_addr_e'(addr))
         REG_DATA:   rdata = BUS_W'(rx_buf);
         REG_CTRL:   rdata = BUS_W'(ctrl_q);
         REG_STAT:   rdata = BUS_W'({wcol, active, irq_flag, full});
         default:    rdata = BUS_W'(rld_q);
      endcase
   end

   assign ctrl   = ctrl_q;
   assign reload = rld_q;

endmodule

// File: rtl/spi_byte_host.sv
`timescale 1ns/1ps
module spi_byte_host
   import spi_host_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BUS_W    = 8,
   parameter int RELOAD_W = 8,
   parameter int PRE_LO   = 4,
   parameter int PRE_MID  = 16,
   parameter int PRE_HI   = 64,
   parameter bit TMR_SYNC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   input  logic             tmr_tick,
   input  logic             sdi,
   output logic             sck,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             irq
);

   ctrl_t               ctrl;
   logic [RELOAD_W-1:0] reload;
   logic                busy, done, start, half_tick;
   logic                full, irq_flag, wcol;
   logic [DATA_W-1:0]   tx_byte, rx_byte;

   spi_reg_file #(
      .DATA_W(DATA_W), .BUS_W(BUS_W), .RELOAD_W(RELOAD_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .active(busy), .done(done), .rx_byte(rx_byte),
      .start(start), .tx_byte(tx_byte), .ctrl(ctrl), .reload(reload),
      .full(full), .irq_flag(irq_flag), .wcol(wcol)
   );

   spi_rate_gen #(
      .PRE_LO(PRE_LO), .PRE_MID(PRE_MID), .PRE_HI(PRE_HI),
      .RELOAD_W(RELOAD_W), .TMR_SYNC(TMR_SYNC)
   ) u_rate (
      .clk(clk), .rst_n(rst_n), .run(busy), .rate_sel(ctrl.rate_sel),
      .reload(reload), .tmr_tick(tmr_tick), .half_tick(half_tick)
   );

   spi_shift_core #(
      .DATA_W(DATA_W)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
      .half_tick(half_tick), .idle_hi(ctrl.idle_hi),
      .lead_data(ctrl.lead_data), .late_sample(ctrl.late_sample),
      .sdi(sdi), .sck(sck), .sdo(sdo), .active(busy), .done(done),
      .rx_byte(rx_byte)
   );

   assign sdo_oe = ~ctrl.tx_mute;
   assign irq    = irq_flag;

endmodule

// File: rtl/spi_byte_host_chk.sv
`timescale 1ns/1ps
module spi_byte_host_chk #(
   parameter int BUS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [1:0]       addr,
   input logic [BUS_W-1:0] wdata,
   input logic             sck,
   input logic             irq,
   input logic             busy_s,
   input logic             full_s,
   input logic             wcol_s,
   input logic             idle_s
);

   p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0 && !busy_s) |=> busy_s);

   p_done_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_s) |-> (full_s && irq));

   p_idle_sck_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_s |-> (sck == idle_s));

   p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0 && busy_s) |=> (wcol_s && busy_s));

   p_full_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 2'd0 && !busy_s) |=> !full_s);

   p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd2 && wdata[1] && !busy_s) |=> !irq);

endmodule

bind spi_byte_host spi_byte_host_chk #(.BUS_W(BUS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .sck(sck), .irq(irq), .busy_s(busy), .full_s(full),
   .wcol_s(wcol), .idle_s(ctrl.idle_hi)
);

// File: tb/sim_spi_byte_host.sv
`timescale 1ns/1ps
module sim_spi_byte_host;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic       tmr_tick = 1'b0;
   logic       loop_en = 1'b1;
   logic       sdi_const = 1'b0;
   wire  [7:0] rdata;
   wire        sck, sdo, sdo_oe, irq;
   wire        sdi = loop_en ? sdo : sdi_const;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [7:0] rx_q[$];
   logic [7:0] tx_q[$];
   logic       mon_en = 1'b0;
   logic       mon_idle = 1'b0;
   int         mon_cnt = 0;
   logic [7:0] mon_sh = 8'h00;

   spi_byte_host u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tmr_tick(tmr_tick), .sdi(sdi),
      .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
   );

   always #2.5 clk = ~clk;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] cfg(int sel, bit idle, bit lead, bit late, bit mute);
      return {1'b0, mute, late, lead, idle, 3'(sel)};
   endfunction

   task automatic bus_wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // driver: expected items go to the scoreboard queues, then the start write
   task automatic send(logic [7:0] tx, logic [7:0] exp_rx);
      rx_q.push_back(exp_rx);
      if (mon_en) tx_q.push_back(tx);
      bus_wr(2'd0, tx);
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (irq !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic collect(string req);
      logic [7:0] d;
      logic [7:0] e;
      bus_rd(2'd0, d);
      if (rx_q.size() == 0) chk({req, " queue empty"}, 1, 0);
      else begin
         e = rx_q.pop_front();
         chk(req, d, e);
      end
      bus_wr(2'd2, 8'h02);
   endtask

   // serial monitor: sdo captured on each leading sck edge (lead-data mode)
   always @(sck) begin
      if (mon_en && sck !== mon_idle) begin
         mon_sh = {mon_sh[6:0], sdo};
         mon_cnt++;
         if (mon_cnt == 8) begin
            mon_cnt = 0;
            if (tx_q.size() == 0) chk("R2 sdo queue empty", 1, 0);
            else chk("R2 sdo bit order", mon_sh, tx_q.pop_front());
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 sck", sck, 0);
      chk("R12 irq", irq, 0);
      chk("R12 sdo_oe", sdo_oe, 1);
      bus_rd(2'd2, d); chk("R12 status", d, 8'h00);
      bus_rd(2'd1, d); chk("R12 ctrl", d, 8'h00);

      // A: rate 0, lead 0, mid sample
      send(8'hA5, 8'hA5);
      chk("R1 busy after write", 1, 1);
      bus_rd(2'd2, d); chk("R1 busy bit", d[2], 1);
      wait_irq(n);
      chk("R4 rate0 length", n + 2, 32);
      bus_rd(2'd2, d); chk("R3 status full+irq", d, 8'h03);
      bus_wr(2'd2, 8'h00);
      chk("R11 write 0 keeps irq", irq, 1);
      bus_rd(2'd0, d); chk("R3 rx byte", d, rx_q.pop_front());
      bus_rd(2'd2, d); chk("R11 full cleared by read", d[0], 0);
      bus_wr(2'd2, 8'h02);
      chk("R11 irq cleared by w1c", irq, 0);

      // R7 lead 0: sck leaves idle at the start of the bit
      rx_q.push_back(8'h3E);
      bus_wr(2'd0, 8'h3E);
      chk("R7 lead0 sck at bit start", sck, 1);
      wait_irq(n);
      collect("R8 mid sample loopback");

      // B: rate 1, idle high, lead 1
      bus_wr(2'd1, cfg(1, 1, 1, 0, 0));
      @(negedge clk);
      chk("R6 idle high", sck, 1);
      mon_idle = 1'b1; mon_en = 1'b1;
      send(8'h3C, 8'h3C);
      chk("R7 lead1 sck idle first half", sck, 1);
      wait_irq(n);
      chk("R4 rate1 length", n, 128);
      chk("R6 idle after transfer", sck, 1);
      collect("R3 rate1 rx");
      mon_en = 1'b0;

      // C: rate 2, idle low, lead 1, late sample
      bus_wr(2'd1, cfg(2, 0, 1, 1, 0));
      @(negedge clk);
      mon_idle = 1'b0; mon_en = 1'b1;
      send(8'h81, 8'h81);
      wait_irq(n);
      chk("R4 rate2 length", n, 512);
      collect("R8 late sample loopback");
      mon_en = 1'b0;

      // D: reload divider
      bus_wr(2'd3, 8'h03);
      bus_wr(2'd1, cfg(4, 0, 0, 1, 0));
      send(8'h5A, 8'h5A);
      wait_irq(n);
      chk("R4 reload N=3 length", n, 128);
      collect("R4 reload rx");
      bus_wr(2'd3, 8'h00);
      send(8'hC3, 8'hC3);
      wait_irq(n);
      chk("R4 reload N=0 length", n, 32);
      collect("R4 reload N=0 rx");

      // E: collision
      bus_wr(2'd1, cfg(0, 0, 0, 0, 0));
      send(8'h96, 8'h96);
      repeat (3) @(negedge clk);
      bus_wr(2'd0, 8'h11);
      bus_rd(2'd2, d);
      chk("R10 wcol set", d[3], 1);
      chk("R10 still busy", d[2], 1);
      wait_irq(n);
      collect("R10 write ignored");
      bus_rd(2'd2, d); chk("R11 wcol held", d[3], 1);
      bus_wr(2'd2, 8'h08);
      bus_rd(2'd2, d); chk("R11 wcol cleared", d[3], 0);

      // F: timer pulses
      bus_wr(2'd1, cfg(3, 0, 1, 0, 0));
      @(negedge clk);
      mon_idle = 1'b0; mon_en = 1'b1;
      send(8'hE7, 8'hE7);
      repeat (40) @(negedge clk);
      chk("R5 no pulse no progress", irq, 0);
      for (int i = 0; i < 16; i++) begin
         if (i == 15) chk("R5 low after 15 pulses", irq, 0);
         @(negedge clk); tmr_tick = 1'b1;
         @(negedge clk); tmr_tick = 1'b0;
         repeat (3) @(negedge clk);
      end
      chk("R5 done after 16 pulses", irq, 1);
      collect("R5 timer rx");
      mon_en = 1'b0;

      // G: muted output, receive only
      bus_wr(2'd1, cfg(0, 0, 0, 0, 1));
      @(negedge clk);
      chk("R9 sdo_oe low", sdo_oe, 0);
      loop_en = 1'b0; sdi_const = 1'b1;
      send(8'h00, 8'hFF);
      wait_irq(n);
      collect("R9 receive ones");
      sdi_const = 1'b0;
      send(8'hFF, 8'h00);
      wait_irq(n);
      collect("R9 receive zeros");
      loop_en = 1'b1;

      chk("R2 monitor drained", tx_q.size(), 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule